// File: doc/BRIEF.md
# Coin Credit Gate Controller

The block is a small Moore controller for a coin slot that accepts only two coin values. Each cycle it can receive a one-cycle pulse for a five-unit coin or for a ten-unit coin. It keeps a running credit in one of four levels: zero, five, ten, and fifteen-or-more. When the credit reaches fifteen or more, it raises a gate-release output and holds it there.

No change is returned. Any credit above fifteen counts the same as fifteen. Once the top level is reached, coins are ignored until a synchronous reset clears the credit.

The design is split into two parts. A control part turns the coin pulses and the reset into a struct of strobes and decodes the output from the held credit level. A datapath part holds the 2-bit credit register and steps it under those strobes. The gate output comes from the register alone, so a coin sampled on one clock edge shows on the output just after that same edge.

Top module: `vendCoinTop`

## Requirements
- R1: While `rst` is high at a rising clock edge, the credit returns to zero and `gateOpen` is low after that edge.
- R2: A `coinFive` pulse adds five to the credit and a `coinTen` pulse adds ten, each applied at the sampling edge, for credit below fifteen.
- R3: `gateOpen` is low whenever the accumulated credit is below fifteen.
- R4: A cycle with neither coin pulse leaves the credit unchanged.
- R5: Once `gateOpen` is high, it stays high under any coin input until a reset.
- R6: `gateOpen` rises just after the edge that samples the coin that first brings the credit to fifteen or more.
- R7: A ten-unit coin at a credit of ten gives the same saturated state as a five-unit coin: the output opens and no excess is kept.
- R8: When both pulses arrive in one cycle, only the ten-unit coin is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the credit |
| coinFive | input | 1 | One-cycle pulse for a five-unit coin |
| coinTen | input | 1 | One-cycle pulse for a ten-unit coin |
| gateOpen | output | 1 | High while the credit is fifteen or more |

## Verification
The bound checker tests several rules on every cycle:
- reset clears the output;
- the output never drops without a reset;
- every rise of the output follows a sampled coin;
- an idle cycle keeps the credit level;
- the single-step moves from zero and ten land where they should.

Some properties can only be shown by the bench's coin sequences, checked against a saturating credit model:
- the exact cycle of the first rise across whole sequences such as five-five-five, five-ten, ten-five and ten-ten;
- the overshoot case;
- the precedence rule when both pulses arrive together.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Width of the credit register
  localparam int CREDIT_W = 2;

  // Credit levels; the binary order follows the credit amount
  typedef enum logic [CREDIT_W-1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_FULL = 2'b11
  } credit_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic addTen;
    logic addFive;
  } creditStrobe_t;

endpackage

// File: rtl/coinCtrl.sv
module coinCtrl
  import vend_pkg::*;
(
  input  logic          rst,
  input  logic          coinFive,
  input  logic          coinTen,
  input  credit_e       creditQ,
  output creditStrobe_t strobe,
  output logic          gateOpen
);

  // Reset wins over coins; a ten-unit coin masks a five-unit one
  always_comb begin
    strobe         = '0;
    strobe.clear   = rst;
    strobe.addTen  = !rst && coinTen;
    strobe.addFive = !rst && coinFive && !coinTen;
  end

  // Moore output: depends on the held credit level only
  always_comb begin
    gateOpen = (creditQ == CR_FULL);
  end

endmodule

// File: rtl/creditPath.sv
module creditPath
  import vend_pkg::*;
(
  input  logic          clk,
  input  creditStrobe_t strobe,
  output credit_e       creditQ
);

  credit_e creditNext;

  always_comb begin
    creditNext = creditQ;
    if (strobe.clear) begin
      creditNext = CR_ZERO;
    end else begin
      unique case (creditQ)
        CR_ZERO: begin
          if (strobe.addTen)       creditNext = CR_TEN;
          else if (strobe.addFive) creditNext = CR_FIVE;
        end
        CR_FIVE: begin
          if (strobe.addTen)       creditNext = CR_FULL;
          else if (strobe.addFive) creditNext = CR_TEN;
        end
        CR_TEN: begin
          if (strobe.addTen || strobe.addFive) creditNext = CR_FULL;
        end
        default: creditNext = CR_FULL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    creditQ <= creditNext;
  end

endmodule

// File: rtl/vendCoinTop.sv
module vendCoinTop
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coinFive,
  input  logic coinTen,
  output logic gateOpen
);

  creditStrobe_t strobe;
  credit_e       creditQ;

  coinCtrl uCtrl (
    .rst      (rst),
    .coinFive (coinFive),
    .coinTen  (coinTen),
    .creditQ  (creditQ),
    .strobe   (strobe),
    .gateOpen (gateOpen)
  );

  creditPath uPath (
    .clk     (clk),
    .strobe  (strobe),
    .creditQ (creditQ)
  );

endmodule

// File: rtl/vendCoinChk.sv
module vendCoinChk
  import vend_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                coinFive,
  input logic                coinTen,
  input logic                gateOpen,
  input logic [CREDIT_W-1:0] creditQ
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !gateOpen);

  a_r5_open_sticks: assert property (@(posedge clk) disable iff (rst)
    gateOpen |=> gateOpen);

  a_r6_rise_needs_coin: assert property (@(posedge clk) disable iff (rst)
    $rose(gateOpen) |-> $past(coinFive || coinTen));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!coinFive && !coinTen) |=> $stable(creditQ));

  a_r2_ten_from_zero: assert property (@(posedge clk) disable iff (rst)
    (creditQ == 2'b00 && coinTen) |=> (creditQ == 2'b10));

  a_r7_ten_level_opens: assert property (@(posedge clk) disable iff (rst)
    (creditQ == 2'b10 && (coinFive || coinTen)) |=> gateOpen);

endmodule

bind vendCoinTop vendCoinChk uChk (
  .clk      (clk),
  .rst      (rst),
  .coinFive (coinFive),
  .coinTen  (coinTen),
  .gateOpen (gateOpen),
  .creditQ  (creditQ)
);

// File: tb/tb_vendCoinTop.sv
module tb_vendCoinTop;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coinFive = 1'b0;
  logic coinTen = 1'b0;
  logic gateOpen;

  int nChecks = 0;
  int nFails = 0;
  int modelCredit = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vendCoinTop dut (
    .clk      (clk),
    .rst      (rst),
    .coinFive (coinFive),
    .coinTen  (coinTen),
    .gateOpen (gateOpen)
  );

  function automatic int nextCredit(int cur, bit r, bit f, bit t);
    int sum;
    if (r) return 0;
    sum = cur;
    if (t) sum = sum + 10;
    else if (f) sum = sum + 5;
    if (sum > 15) sum = 15;
    return sum;
  endfunction

  function automatic bit expOpen(int cur);
    return cur >= 15;
  endfunction

  task automatic check(string tag, bit got, bit exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: gateOpen actual %0b expected %0b", tag, got, exp);
    end
  endtask

  // Drive at negedge, the model updates at posedge, sample 2 ns later
  task automatic step(bit r, bit f, bit t);
    string tag;
    int prev;
    @(negedge clk);
    rst = r; coinFive = f; coinTen = t;
    @(posedge clk);
    prev = modelCredit;
    modelCredit = nextCredit(modelCredit, r, f, t);
    #2;
    if (r) tag = "R1";
    else if (prev >= 15) tag = "R5";
    else if (f && t) tag = "R8";
    else if (!f && !t) tag = "R4";
    else if (prev == 10 && t) tag = "R7";
    else if (modelCredit >= 15) tag = "R6";
    else tag = "R2";
    check(tag, gateOpen, expOpen(modelCredit));
    if (modelCredit < 15) check("R3", gateOpen, 1'b0);
  endtask

  task automatic coinSeq(bit f0, bit t0, bit f1, bit t1, bit f2, bit t2);
    step(1, 0, 0);
    step(0, f0, t0);
    step(0, f1, t1);
    step(0, f2, t2);
    step(0, 0, 0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    step(1, 0, 0);
    step(1, 0, 0);
    check("R1", gateOpen, 1'b0);

    // Directed sequences
    coinSeq(1, 0, 1, 0, 1, 0);   // five five five
    coinSeq(1, 0, 0, 1, 0, 0);   // five ten
    coinSeq(0, 1, 1, 0, 0, 0);   // ten five
    coinSeq(0, 1, 0, 1, 1, 0);   // ten ten, then more
    // Both pulses together counted as a ten-unit coin
    step(1, 0, 0);
    step(0, 1, 1);   // 10
    step(0, 0, 0);
    step(0, 1, 0);   // 15
    step(1, 0, 0);
    step(0, 1, 0);   // 5
    step(0, 1, 1);   // 15
    // Idle gaps between coins
    step(1, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 1);

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      int pick;
      bit r;
      bit f;
      bit t;
      pick = int'($urandom_range(0, 99));
      r = (pick < 4);
      f = (pick >= 40 && pick < 70) || (pick >= 95);
      t = (pick >= 70);
      step(r, f, t);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule